// File: doc/BRIEF.md
# Two-Device Programmed-I/O Strobe Timer

This block produces the address-enable, strobe and data-latch timing for programmed-I/O cycles on a parallel storage bus shared by two devices. Timing is kept per speed class and not per device. One timing word serves the slower device and a second serves the faster one. A control bit records which device number counts as fast. Each timing word carries four phase fields. A field value N yields N+1 system clocks for its phase, which accounts for the fixed extra clock the hardware always adds.

An access request is accepted only while the block is idle. The timing set is picked from the drive-select bit taken from the most recent device/head register write. The block then runs setup, strobe-active, hold and recovery in that order. A device holding its ready line low stretches the strobe-active phase. If the wait runs past a programmable limit, the cycle is cut short and a sticky timeout flag is raised.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset both timing words hold setup 6, active 19, recovery 15 and hold 2. The fast-device bit is 0, the latched drive select is 0, the wait field is 11 and the timeout flag is clear. The block is idle with strobe and address enable low.
- R2: An accepted access runs setup, active, hold and recovery in that order, each lasting its field value plus one clocks. The address enable is high in setup, active and hold. The strobe is high in active only. Busy is high from the clock after acceptance until recovery ends.
- R3: A timing word (cfg_addr 0 = slow set, 1 = fast set) holds setup in bits 30:27, active in bits 25:20, recovery in bits 18:13 and hold in bits 11:9.
- R4: The fast set is used when the latched drive select equals bit 28 of the control word (cfg_addr 2). Otherwise the slow set is used.
- R5: A dev_we pulse latches dev_bit as the drive select for all later accesses.
- R6: acc_req is accepted only while idle. A request made during an access is dropped and not queued.
- R7: Once the programmed active length has elapsed, the active phase continues while iordy is low. It ends in the first clock in which iordy is sampled high.
- R8: The wait field sits in bits 26:23 of the timeout word (cfg_addr 3). With field F, at most 8*F+1 clocks are spent waiting on a low iordy. After that the active phase ends, and the timeout flag sets and stays set until reset.
- R9: latch_en pulses for one clock in the final active clock of a cycle that ends with iordy high. It does not pulse on a timed-out cycle.
- R10: The timing and wait values are captured when an access is accepted. Configuration writes made during an access change only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 slow timing, 1 fast timing, 2 control, 3 timeout |
| cfg_wdata | input | 32 | Configuration write data |
| dev_we | input | 1 | Device/head register write seen |
| dev_bit | input | 1 | Drive-select bit of that write |
| acc_req | input | 1 | Start a programmed-I/O access |
| iordy | input | 1 | Device ready, low to extend |
| busy | output | 1 | Access in progress |
| addr_en | output | 1 | Address and chip selects driven |
| strobe | output | 1 | Read/write strobe asserted |
| latch_en | output | 1 | Data capture pulse at strobe end |
| rdy_timeout | output | 1 | Sticky ready-timeout flag |

## Verification
The hardest case to reach from the ports is the boundary of the ready wait, where one more low clock turns a stretched cycle into a timed-out one. The bench holds iordy low for a chosen number of strobe clocks, counted at the strobe itself. It places that release just inside, exactly at, and one past the 8*F+1 limit, and checks the active length, the latch pulse and the flag in each case. Writes that arrive during an access are placed at a known clock inside the cycle, so the effect of the captured values can be observed.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  localparam int SETUP_LSB   = 27;
  localparam int SETUP_W     = 4;
  localparam int ACT_LSB     = 20;
  localparam int ACT_W       = 6;
  localparam int REC_LSB     = 13;
  localparam int REC_W       = 6;
  localparam int HOLD_LSB    = 9;
  localparam int HOLD_W      = 3;
  localparam int FASTDEV_BIT = 28;
  localparam int WAIT_LSB    = 23;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [ACT_W-1:0]   act;
    logic [REC_W-1:0]   rec;
    logic [HOLD_W-1:0]  hold;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD, PH_RECOVER
  } phase_e;

  function automatic timing_t unpack_timing(input logic [31:0] w);
    timing_t t;
    t.setup = w[SETUP_LSB +: SETUP_W];
    t.act   = w[ACT_LSB   +: ACT_W];
    t.rec   = w[REC_LSB   +: REC_W];
    t.hold  = w[HOLD_LSB  +: HOLD_W];
    return t;
  endfunction

  function automatic timing_t make_timing(input int unsigned s, input int unsigned a,
                                          input int unsigned r, input int unsigned h);
    timing_t t;
    t.setup = SETUP_W'(s);
    t.act   = ACT_W'(a);
    t.rec   = REC_W'(r);
    t.hold  = HOLD_W'(h);
    return t;
  endfunction

  // number of clocks spent waiting on a low ready before giving up
  function automatic int unsigned wait_clocks(input int unsigned field);
    return 8 * field + 1;
  endfunction
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_strobe_pkg::*;
#(
  parameter int TMO_W   = 4,
  parameter int TMO_RST = 11,
  parameter int DEF_S   = 6,
  parameter int DEF_A   = 19,
  parameter int DEF_R   = 15,
  parameter int DEF_H   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             dev_we,
  input  logic             dev_bit,
  output timing_t          sel_timing,
  output logic [TMO_W-1:0] wait_field
);
  localparam timing_t DEF_T = make_timing(DEF_S, DEF_A, DEF_R, DEF_H);

  timing_t slow_q, fast_q;
  logic    fast_dev_q, drive_q;
  logic    unused_bits;

  assign unused_bits = ^{cfg_wdata[31], cfg_wdata[8:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q     <= DEF_T;
      fast_q     <= DEF_T;
      fast_dev_q <= 1'b0;
      wait_field <= TMO_W'(TMO_RST);
      drive_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: slow_q     <= unpack_timing(cfg_wdata);
          2'd1: fast_q     <= unpack_timing(cfg_wdata);
          2'd2: fast_dev_q <= cfg_wdata[FASTDEV_BIT];
          default: wait_field <= cfg_wdata[WAIT_LSB +: TMO_W];
        endcase
      end
      if (dev_we) drive_q <= dev_bit;
    end
  end

  assign sel_timing = (drive_q == fast_dev_q) ? fast_q : slow_q;
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_strobe_pkg::*;
#(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic             iordy,
  input  timing_t          sel_timing,
  input  logic [TMO_W-1:0] wait_field,
  output logic             accept,
  output logic             timeout_hit,
  output logic             busy,
  output logic             addr_en,
  output logic             strobe,
  output logic             latch_en,
  output logic             rdy_timeout
);
  localparam int CNT_W  = ACT_W + 1;
  localparam int WAIT_W = TMO_W + 4;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [WAIT_W-1:0] wcnt;
  timing_t          cur;
  logic [TMO_W-1:0] cur_wait;
  logic             min_done, step_done;

  assign accept      = (phase == PH_IDLE) && acc_req;
  assign min_done    = (phase == PH_ACTIVE) && (cnt == CNT_W'(cur.act));
  assign timeout_hit = min_done && !iordy &&
                       (wcnt == WAIT_W'(wait_clocks(32'(cur_wait)) - 1));

  always_comb begin
    case (phase)
      PH_SETUP:   step_done = (cnt == CNT_W'(cur.setup));
      PH_HOLD:    step_done = (cnt == CNT_W'(cur.hold));
      PH_RECOVER: step_done = (cnt == CNT_W'(cur.rec));
      default:    step_done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      wcnt        <= '0;
      cur         <= '0;
      cur_wait    <= '0;
      rdy_timeout <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          cur      <= sel_timing;
          cur_wait <= wait_field;
          cnt      <= '0;
          phase    <= PH_SETUP;
        end
        PH_ACTIVE: begin
          if (!min_done) cnt <= cnt + 1'b1;
          else if (iordy || timeout_hit) begin
            cnt   <= '0;
            phase <= PH_HOLD;
            if (timeout_hit) rdy_timeout <= 1'b1;
          end else wcnt <= wcnt + 1'b1;
        end
        default: begin
          if (!step_done) cnt <= cnt + 1'b1;
          else begin
            cnt  <= '0;
            wcnt <= '0;
            case (phase)
              PH_SETUP: phase <= PH_ACTIVE;
              PH_HOLD:  phase <= PH_RECOVER;
              default:  phase <= PH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign strobe   = (phase == PH_ACTIVE);
  assign addr_en  = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
  assign latch_en = min_done && iordy;
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_strobe_pkg::*;
#(
  parameter int TMO_W   = 4,
  parameter int TMO_RST = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        dev_we,
  input  logic        dev_bit,
  input  logic        acc_req,
  input  logic        iordy,
  output logic        busy,
  output logic        addr_en,
  output logic        strobe,
  output logic        latch_en,
  output logic        rdy_timeout
);
  timing_t          sel_timing;
  logic [TMO_W-1:0] wait_field;
  logic             accept, timeout_hit;

  pio_cfg_regs #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dev_we(dev_we), .dev_bit(dev_bit),
    .sel_timing(sel_timing), .wait_field(wait_field)
  );

  pio_phase_seq #(.TMO_W(TMO_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .iordy(iordy),
    .sel_timing(sel_timing), .wait_field(wait_field),
    .accept(accept), .timeout_hit(timeout_hit),
    .busy(busy), .addr_en(addr_en), .strobe(strobe),
    .latch_en(latch_en), .rdy_timeout(rdy_timeout)
  );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic iordy,
  input logic busy,
  input logic addr_en,
  input logic strobe,
  input logic latch_en,
  input logic rdy_timeout,
  input logic accept,
  input logic timeout_hit
);
  a_r2_strobe_inside_addr: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (addr_en && busy));

  a_r2_end_from_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(addr_en));

  a_r6_accept_enters_setup: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && addr_en && !strobe));

  a_r9_latch_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> (strobe && iordy && !timeout_hit));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_timeout |=> rdy_timeout);

  a_r8_flag_at_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_timeout) |-> ($past(strobe) && !strobe && !$past(iordy)));
endmodule

bind pio_strobe_timer pio_strobe_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .iordy(iordy), .busy(busy), .addr_en(addr_en),
  .strobe(strobe), .latch_en(latch_en), .rdy_timeout(rdy_timeout),
  .accept(accept), .timeout_hit(timeout_hit)
);

// File: tb/pio_strobe_timer_tb_top.sv
module pio_strobe_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dev_we = 1'b0;
  logic        dev_bit = 1'b0;
  logic        acc_req = 1'b0;
  logic        iordy = 1'b1;
  logic        busy, addr_en, strobe, latch_en, rdy_timeout;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dev_we(dev_we), .dev_bit(dev_bit),
    .acc_req(acc_req), .iordy(iordy), .busy(busy), .addr_en(addr_en),
    .strobe(strobe), .latch_en(latch_en), .rdy_timeout(rdy_timeout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int s, input int a, input int r, input int h);
    return (32'(s) << 27) | (32'(a) << 20) | (32'(r) << 13) | (32'(h) << 9);
  endfunction

  function automatic int pack4(input int s, input int a, input int h, input int r);
    return (s << 24) | (a << 16) | (h << 8) | r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic dev_write(input bit b);
    @(negedge clk);
    dev_we = 1'b1; dev_bit = b;
    @(negedge clk);
    dev_we = 1'b0;
  endtask

  // low_n: strobe clocks with iordy low; poke_kind 1 = extra request, 2 = zero slow timing write
  task automatic run_access(input int low_n, input int poke_at, input int poke_kind,
                            output int s, output int a, output int h, output int r,
                            output int lat);
    int idx = 0;
    bit seen = 0;
    s = 0; a = 0; h = 0; r = 0; lat = 0;
    @(negedge clk);
    acc_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
    while (busy && idx < 3000) begin
      acc_req = 1'b0;
      cfg_we  = 1'b0;
      if (idx == poke_at && poke_kind == 1) acc_req = 1'b1;
      if (idx == poke_at && poke_kind == 2) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = '0;
      end
      if (strobe) begin
        iordy = (a >= low_n);
        #1;
        if (latch_en) lat++;
        a++;
        seen = 1;
      end else begin
        iordy = 1'b1;
        if (addr_en) begin
          if (seen) h++; else s++;
        end else r++;
      end
      idx++;
      @(negedge clk);
    end
    acc_req = 1'b0;
    cfg_we  = 1'b0;
    iordy   = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, a, h, r, lat;
    int ea;
    bit et, flag;
    do_reset();
    @(negedge clk);
    check(!busy && !strobe && !addr_en && !rdy_timeout && !latch_en, "R1",
          "idle outputs after reset", {busy, strobe, addr_en, rdy_timeout}, 0);

    // defaults 6/19/15/2 -> 7,20,3,16 clocks
    run_access(0, -1, 0, s, a, h, r, lat);
    check(pack4(s, a, h, r) == pack4(7, 20, 3, 16), "R1", "default phase lengths",
          pack4(s, a, h, r), pack4(7, 20, 3, 16));
    check(lat == 1, "R9", "latch pulses on default access", lat, 1);

    // sweep the fast set (device 0 is fast after reset)
    for (int si = 0; si < 16; si++)
      for (int hi = 0; hi < 8; hi++)
        for (int ai = 0; ai < 3; ai++)
          for (int ri = 0; ri < 2; ri++) begin
            int av = (ai == 0) ? 0 : (ai == 1) ? 5 : 63;
            int rv = (ri == 0) ? 0 : 63;
            cfg_write(1, tword(si, av, rv, hi));
            run_access(0, -1, 0, s, a, h, r, lat);
            check(pack4(s, a, h, r) == pack4(si + 1, av + 1, hi + 1, rv + 1), "R2",
                  "swept phase lengths (R3 field layout)", pack4(s, a, h, r),
                  pack4(si + 1, av + 1, hi + 1, rv + 1));
          end

    // device select against fast-device bit
    cfg_write(0, tword(1, 2, 3, 4));
    cfg_write(1, tword(5, 6, 7, 1));
    for (int fd = 0; fd < 2; fd++)
      for (int dv = 0; dv < 2; dv++) begin
        int exp;
        cfg_write(2, 32'(fd) << 28);
        dev_write(dv[0]);
        run_access(0, -1, 0, s, a, h, r, lat);
        exp = (fd == dv) ? pack4(6, 7, 2, 8) : pack4(2, 3, 5, 4);
        check(pack4(s, a, h, r) == exp, "R4", "timing set per drive select (R5 latch)",
              pack4(s, a, h, r), exp);
      end

    // ready extension and timeout: fast active 3, F=2 -> 17 wait clocks
    do_reset();
    cfg_write(1, tword(0, 3, 0, 0));
    cfg_write(3, 32'd2 << 23);
    flag = 0;
    foreach (ea_list[k]) begin
      int L = ea_list[k];
      if (L <= 3) begin ea = 4; et = 0; end
      else if (L - 3 <= 16) begin ea = L + 1; et = 0; end
      else begin ea = 3 + 17; et = 1; end
      flag = flag | et;
      run_access(L, -1, 0, s, a, h, r, lat);
      check(a == ea, et ? "R8" : "R7", "active length with ready low", a, ea);
      check(lat == (et ? 0 : 1), "R9", "latch pulse count", lat, et ? 0 : 1);
      check(rdy_timeout == flag, "R8", "sticky timeout flag", rdy_timeout, flag);
    end
    do_reset();
    @(negedge clk);
    check(!rdy_timeout, "R1", "flag cleared by reset", rdy_timeout, 0);

    // request during an access is dropped
    run_access(0, 3, 1, s, a, h, r, lat);
    repeat (3) begin
      @(negedge clk);
      check(!busy, "R6", "no queued access after busy request", busy, 0);
    end

    // write during access affects only the next one
    cfg_write(2, 32'd1 << 28);
    cfg_write(0, tword(2, 4, 3, 1));
    run_access(0, 1, 2, s, a, h, r, lat);
    check(pack4(s, a, h, r) == pack4(3, 5, 2, 4), "R10", "captured timing kept",
          pack4(s, a, h, r), pack4(3, 5, 2, 4));
    run_access(0, -1, 0, s, a, h, r, lat);
    check(pack4(s, a, h, r) == pack4(1, 1, 1, 1), "R10", "new timing on next access",
          pack4(s, a, h, r), pack4(1, 1, 1, 1));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int ea_list[8] = '{0, 2, 4, 10, 19, 20, 21, 40};
endmodule